// File: doc/BRIEF.md
# Speculative Load Snoop Violation Detector

This block keeps an in-order record of memory loads that a speculative core has issued but not yet retired. Each load takes a slot when it issues, records its cache-line address when it has actually read memory, and gives up its slot in program order when it retires. Every write observed from another agent is compared against the slots that have read memory but not yet retired. A write to the same 64-byte line as any such load means the core consumed a value that is now stale. The block then pulses a flush request and discards every tracked load.

A pause hint lets software serialize its spin-wait loops. While the hint is in force, a new load may only issue into an empty queue. The load issued after the queue drains must retire before another may issue. This shrinks the window in which a remote write can catch an executed, unretired load.

Top module: `load_snoop_guard`

## Requirements
- R1: After reset `alloc_ready_o` is 1, `alloc_tag_o` is 0 and `flush_o` is 0.
- R2: Accepted loads receive tags 0,1,2,... in order, wrapping from DEPTH-1 (7 by default) back to 0.
- R3: `commit_valid_i` retires the oldest load only if that load has executed; otherwise it is ignored and the oldest load stays tracked.
- R4: A snoop whose address bits [ADDR_W-1:6] equal those of an executed, unretired load makes `flush_o` 1 for exactly the one cycle after the snoop cycle.
- R5: A snoop to a different 64-byte line than every executed, unretired load raises no flush.
- R6: A load that is allocated but not yet executed never matches a snoop.
- R7: A load that has retired never matches a snoop.
- R8: A flush invalidates all loads. `alloc_ready_o` is 0 during the cycle `flush_o` is 1, and the next accepted load gets tag 0.
- R9: A snoop is compared with the tracked state as it stood before the same cycle's execute, retire and allocate. Retiring the matching load in the snoop cycle still flushes. Executing a load to the snooped line in the snoop cycle does not.
- R10: While `pause_i` is 1 or pause mode is held, `alloc_ready_o` is 0 whenever any load is tracked.
- R11: Pause mode persists after `pause_i` falls. The first load accepted into the empty queue blocks further loads until it retires. Pause mode then ends unless `pause_i` is 1.
- R12: With DEPTH loads tracked, `alloc_ready_o` is 0. A request made then is not accepted and does not advance the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Request to issue a load |
| alloc_ready_o | output | 1 | A load may issue this cycle |
| alloc_tag_o | output | IDX_W | Tag given to the load issued this cycle |
| exec_valid_i | input | 1 | A tracked load has read memory |
| exec_tag_i | input | IDX_W | Tag of the load that read memory |
| exec_addr_i | input | ADDR_W | Byte address it read |
| commit_valid_i | input | 1 | Retire the oldest load |
| pause_i | input | 1 | Spin-wait pause hint |
| snoop_valid_i | input | 1 | A write from another agent is seen |
| snoop_addr_i | input | ADDR_W | Byte address of that write |
| flush_o | output | 1 | One-cycle pipeline flush request |

## Verification
The hardest condition to reach is a snoop that lands in the same cycle as the retire or the execution of the very load it targets. In that cycle the ordering rule decides whether a flush is raised. The bench reaches it by driving the retire or execute strobe together with a snoop to the matching line from one negative edge. It then reads the flush pulse one cycle later. Pause persistence is reached by dropping the hint once the queue has drained and issuing one load. The bench then shows that a second load is refused until the first retires.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_DONE = 2'd2
  } slot_e;
endpackage

// File: rtl/lsg_slot.sv
module lsg_slot
  import lsg_pkg::*;
#(
  parameter int LINE_W = 34
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              alloc_i,
  input  logic              exec_i,
  input  logic [LINE_W-1:0] exec_line_i,
  input  logic              free_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  output slot_e             state_o,
  output logic              hit_o
);
  slot_e             state_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_FREE;
      line_q  <= '0;
    end else if (clear_i) begin
      state_q <= SLOT_FREE;
    end else if (free_i) begin
      state_q <= SLOT_FREE;
    end else if (alloc_i) begin
      state_q <= SLOT_WAIT;
    end else if (exec_i && state_q == SLOT_WAIT) begin
      state_q <= SLOT_DONE;
      line_q  <= exec_line_i;
    end
  end

  // only loads that have read memory take part in the compare
  assign hit_o   = (state_q == SLOT_DONE) && (line_q == snoop_line_i);
  assign state_o = state_q;

  p_done_needs_exec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_DONE && $past(state_q) != SLOT_DONE) |-> $past(exec_i));
endmodule

// File: rtl/lsg_queue_ctrl.sv
module lsg_queue_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             flush_busy_i,
  input  logic             alloc_req_i,
  input  logic             commit_req_i,
  input  logic             head_done_i,
  input  logic             pause_i,
  output logic             alloc_ready_o,
  output logic             alloc_fire_o,
  output logic             commit_fire_o,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             pause_q, pause_load_q;
  logic             full, empty, pause_eff;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);
  assign pause_eff = pause_i | pause_q;

  assign alloc_ready_o = !full && !flush_busy_i && !(pause_eff && !empty);
  assign alloc_fire_o  = alloc_req_i && alloc_ready_o;
  assign commit_fire_o = commit_req_i && !empty && head_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q       <= '0;
      tail_q       <= '0;
      count_q      <= '0;
      pause_q      <= 1'b0;
      pause_load_q <= 1'b0;
    end else if (clear_i) begin
      head_q       <= '0;
      tail_q       <= '0;
      count_q      <= '0;
      pause_load_q <= 1'b0;
      pause_q      <= pause_i | pause_q;
    end else begin
      if (alloc_fire_o)  tail_q <= wrap_inc(tail_q);
      if (commit_fire_o) head_q <= wrap_inc(head_q);
      case ({alloc_fire_o, commit_fire_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      // pause ends when the load issued into the drained queue retires
      pause_q <= pause_i | (pause_q & !(commit_fire_o & pause_load_q));
      if (alloc_fire_o && pause_eff) pause_load_q <= 1'b1;
      else if (commit_fire_o)        pause_load_q <= 1'b0;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;

  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_full_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |=> !(count_q > $past(count_q)));
  p_pause_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_load_q |-> count_q <= CNT_W'(1));
  p_commit_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_fire_o && !clear_i) |=> head_q != $past(head_q) || DEPTH == 1);
endmodule

// File: rtl/load_snoop_guard.sv
module load_snoop_guard
  import lsg_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int LINE_OFF = $clog2(LINE_BYTES),
  localparam int LINE_W   = ADDR_W - LINE_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_tag_o,
  input  logic              exec_valid_i,
  input  logic [IDX_W-1:0]  exec_tag_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              commit_valid_i,
  input  logic              pause_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              flush_o
);
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             alloc_fire, commit_fire, flush_q, violation;
  logic [DEPTH-1:0] hit_vec;
  slot_e            state_vec [DEPTH];

  assign violation = snoop_valid_i && (|hit_vec);

  lsg_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (violation),
    .flush_busy_i  (flush_q),
    .alloc_req_i   (alloc_valid_i),
    .commit_req_i  (commit_valid_i),
    .head_done_i   (state_vec[head] == SLOT_DONE),
    .pause_i       (pause_i),
    .alloc_ready_o (alloc_ready_o),
    .alloc_fire_o  (alloc_fire),
    .commit_fire_o (commit_fire),
    .head_o        (head),
    .tail_o        (tail),
    .count_o       (count)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    lsg_slot #(.LINE_W(LINE_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clear_i      (violation),
      .alloc_i      (alloc_fire && tail == IDX_W'(i)),
      .exec_i       (exec_valid_i && exec_tag_i == IDX_W'(i)),
      .exec_line_i  (exec_addr_i[ADDR_W-1:LINE_OFF]),
      .free_i       (commit_fire && head == IDX_W'(i)),
      .snoop_line_i (snoop_addr_i[ADDR_W-1:LINE_OFF]),
      .state_o      (state_vec[i]),
      .hit_o        (hit_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= violation;
  end

  assign flush_o     = flush_q;
  assign alloc_tag_o = tail;

  p_flush_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  p_flush_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(snoop_valid_i));
  p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (count == '0 && !alloc_ready_o));
  p_pause_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && count != '0) |-> !alloc_ready_o);
endmodule

// File: tb/load_snoop_guard_bench.sv
`timescale 1ns/1ps
module load_snoop_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, exec_valid = 1'b0, commit_valid = 1'b0;
  logic        pause = 1'b0, snoop_valid = 1'b0;
  logic [2:0]  exec_tag = '0;
  logic [39:0] exec_addr = '0, snoop_addr = '0;
  logic        alloc_ready, flush;
  logic [2:0]  alloc_tag;
  logic        rdy_s, flush_s;
  logic [2:0]  tag_s;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  load_snoop_guard u_load_snoop_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
    .exec_valid_i(exec_valid), .exec_tag_i(exec_tag), .exec_addr_i(exec_addr),
    .commit_valid_i(commit_valid), .pause_i(pause),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr), .flush_o(flush)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample combinational outputs before the edge, flush after it
  task automatic step(input logic a, input logic e, input logic [2:0] et, input logic [39:0] ea,
                      input logic c, input logic s, input logic [39:0] sa);
    @(negedge clk);
    alloc_valid = a; exec_valid = e; exec_tag = et; exec_addr = ea;
    commit_valid = c; snoop_valid = s; snoop_addr = sa;
    #1;
    rdy_s = alloc_ready; tag_s = alloc_tag;
    @(posedge clk); #1;
    flush_s = flush;
    alloc_valid = 0; exec_valid = 0; commit_valid = 0; snoop_valid = 0;
  endtask

  task automatic idle();            step(0, 0, 0, '0, 0, 0, '0); endtask
  task automatic alloc();           step(1, 0, 0, '0, 0, 0, '0); endtask
  task automatic exec(input logic [2:0] t, input logic [39:0] a); step(0, 1, t, a, 0, 0, '0); endtask
  task automatic commit();          step(0, 0, 0, '0, 1, 0, '0); endtask
  task automatic snoop(input logic [39:0] a); step(0, 0, 0, '0, 0, 1, a); endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pause = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 ready", alloc_ready, 1);
    chk("R1 tag", alloc_tag, 0);
    chk("R1 flush", flush, 0);
  endtask

  task automatic t_commit_gate();
    do_reset();
    for (int i = 0; i < 3; i++) begin alloc(); chk("R2 tag order", tag_s, i); end
    exec(1, 40'h3000);
    commit();                      // head (tag0) not executed: ignored
    exec(0, 40'h2000);
    snoop(40'h2010);
    chk("R3 unexecuted head kept", flush_s, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 8; i++) begin alloc(); chk("R2 ready", rdy_s, 1); chk("R2 tag", tag_s, i); end
    alloc();
    chk("R12 full not ready", rdy_s, 0);
    exec(0, 40'h100);
    commit();
    alloc();
    chk("R12 ready after retire", rdy_s, 1);
    chk("R2 wrap tag", tag_s, 0);
  endtask

  task automatic t_match();
    do_reset();
    alloc(); alloc();
    snoop(40'h0);
    chk("R6 waiting load no match", flush_s, 0);
    exec(0, 40'h1000);
    snoop(40'h2000);
    chk("R5 other line", flush_s, 0);
    snoop(40'h103F);
    chk("R4 same line flush", flush_s, 1);
    idle();
    chk("R4 one-cycle pulse", flush_s, 0);
    chk("R8 not ready in flush cycle", rdy_s, 0);
    alloc();
    chk("R8 ready after flush", rdy_s, 1);
    chk("R8 tag reset", tag_s, 0);
    snoop(40'h1000);
    chk("R8 entries invalidated", flush_s, 0);
  endtask

  task automatic t_retired();
    do_reset();
    alloc(); exec(0, 40'h5000); commit();
    snoop(40'h5000);
    chk("R7 retired no match", flush_s, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    alloc(); exec(0, 40'h7000);
    step(0, 0, 0, '0, 1, 1, 40'h7004);
    chk("R9 retire with snoop flushes", flush_s, 1);
    do_reset();
    alloc();
    step(0, 1, 0, 40'h8000, 0, 1, 40'h8000);
    chk("R9 exec with snoop no flush", flush_s, 0);
    snoop(40'h8020);
    chk("R9 later snoop flushes", flush_s, 1);
  endtask

  task automatic t_pause();
    do_reset();
    alloc(); alloc();
    pause = 1;
    alloc();
    chk("R10 blocked while occupied", rdy_s, 0);
    exec(0, 40'h10); commit();
    alloc();
    chk("R10 still blocked", rdy_s, 0);
    exec(1, 40'h20); commit();
    pause = 0;
    alloc();
    chk("R11 issue into drained queue", rdy_s, 1);
    chk("R11 tag", tag_s, 2);
    alloc();
    chk("R11 pause held after hint", rdy_s, 0);
    exec(2, 40'h30); commit();
    alloc();
    chk("R11 pause ended", rdy_s, 1);
    alloc();
    chk("R11 normal issue", rdy_s, 1);
  endtask

  initial begin
    t_reset();
    t_commit_gate();
    t_full();
    t_match();
    t_retired();
    t_same_cycle();
    t_pause();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule